// File: doc/BRIEF.md
# TLP Traffic Class Dispatcher

This block sits in a PCIe-style receive path after header parsing. It accepts a stream of 32-bit transaction-layer packet words over a valid/ready handshake. A start-of-packet marker flags the first word, and an end-of-packet marker flags the last. From the first word the block reads the format, type and traffic-class fields. It classifies the packet as posted, non-posted or completion, and looks the traffic class up in a small programmable map that picks virtual channel 0 or 1. It then sends every word of the packet to one of nine per-channel queue interfaces. Header words go to a header queue and the remaining words go to the matching data queue.

Software or a reset-time preload fills the class-to-channel map. Three conditions force a packet onto channel 0: traffic class 0, any non-posted request, and a low channel-1 enable. A non-posted request travels as a single unit, header and optional data word together, into one shared queue. A completion that claims a 4-word header is malformed. It is reported on an error pulse and consumed without being forwarded. Every output is registered. A stalled destination backpressures the input stream without losing or reordering words.

Top module: `tlp_tc_dispatch`

## Requirements
- R1: The traffic class is taken from bits 22:20 of the first word. If the map entry for that class is 1 and the packet may use channel 1, the packet goes to channel 1. Queue indices are: 0 posted header ch0, 1 posted data ch0, 2 non-posted combined, 3 completion header ch0, 4 completion data ch0, 5 posted header ch1, 6 posted data ch1, 7 completion header ch1, 8 completion data ch1.
- R2: A packet with traffic class 0 always uses channel 0, even when map entry 0 has been written with 1.
- R3: Reset loads the map from parameter `MAP_INIT` (bit n is class n; the default 8'hF0 sends classes 4 to 7 to channel 1). A write with `tbl_we` high updates one entry at the clock edge. A packet whose first word is accepted at that same edge still uses the old entry.
- R4: Classification uses format bits 31:29 and type bits 28:24 of the first word. Posted means type 10xxx (message), or type 00000 with format bit 1 set (memory write). Completion means type 0101x. Every other type is non-posted.
- R5: For posted and completion packets, the first 3 words go to the header queue when format bit 0 is 0, or the first 4 words when it is 1. All later words go to the data queue of the same class and channel.
- R6: Every word of a non-posted packet goes to queue 2, whatever its traffic class maps to.
- R7: When `vc1_en` is low at the first word, the whole packet uses channel 0 queues. A change of `vc1_en` later in the packet does not move its remaining words.
- R8: A completion with format bit 0 set raises `err_cpl4` for exactly the one cycle after its first word is accepted. All of its words are accepted, and none appears on any output.
- R9: An accepted word appears on the outputs in the next cycle. While the presented word's queue has ready low, `in_ready` is low and the output is held unchanged. No word is lost, duplicated or reordered.
- R10: At most one `out_valid` bit is high at a time. After reset no output is valid, `err_cpl4` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Map entry write strobe |
| tbl_tc | input | 3 | Traffic class of the entry to write |
| tbl_vc | input | 1 | Channel value written (1 = channel 1) |
| vc1_en | input | 1 | Channel 1 enable |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W | Packet word |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| out_valid | output | 9 | Per-queue valid, one-hot or zero |
| out_ready | input | 9 | Per-queue ready |
| out_data | output | DATA_W | Word presented to the selected queue |
| out_eop | output | 1 | Last word of the packet |
| err_cpl4 | output | 1 | One-cycle pulse for a dropped 4-word completion |

## Verification
Two functions can fall in the same cycle. One is a map write to the class of a packet whose first word is accepted at that same edge. The other is a change of the channel-1 enable in the middle of a packet. The bench drives the map write on the same cycle as an unobstructed first word. It expects that packet on channel 0, and expects the next packet of that class on channel 1. It also toggles the enable on a later word and expects all remaining words to stay in the queues chosen at the first word. A cycle-level reference decides queue and order, and random per-queue backpressure runs the same paths under stalls.

// File: rtl/tlpd_pkg.sv
package tlpd_pkg;

  localparam int NUM_TC = 8;
  localparam int TC_W   = $clog2(NUM_TC);
  localparam int NUM_Q  = 9;
  localparam int QW     = $clog2(NUM_Q);

  localparam logic [QW-1:0] Q_PH0 = QW'(0);
  localparam logic [QW-1:0] Q_PD0 = QW'(1);
  localparam logic [QW-1:0] Q_NP  = QW'(2);
  localparam logic [QW-1:0] Q_CH0 = QW'(3);
  localparam logic [QW-1:0] Q_CD0 = QW'(4);
  localparam logic [QW-1:0] Q_PH1 = QW'(5);
  localparam logic [QW-1:0] Q_PD1 = QW'(6);
  localparam logic [QW-1:0] Q_CH1 = QW'(7);
  localparam logic [QW-1:0] Q_CD1 = QW'(8);

  typedef enum logic [1:0] {
    CLS_POSTED    = 2'd0,
    CLS_NONPOSTED = 2'd1,
    CLS_COMPL     = 2'd2
  } tlp_class_e;

  function automatic tlp_class_e decode_class(input logic [2:0] fmt,
                                              input logic [4:0] typ);
    if (typ[4:3] == 2'b10)                 return CLS_POSTED;
    else if (typ[4:1] == 4'b0101)          return CLS_COMPL;
    else if (typ == 5'b00000 && fmt[1])    return CLS_POSTED;
    else                                   return CLS_NONPOSTED;
  endfunction

  function automatic logic [QW-1:0] pick_queue(input tlp_class_e cls,
                                               input logic vc1,
                                               input logic is_hdr);
    case (cls)
      CLS_POSTED: return is_hdr ? (vc1 ? Q_PH1 : Q_PH0) : (vc1 ? Q_PD1 : Q_PD0);
      CLS_COMPL:  return is_hdr ? (vc1 ? Q_CH1 : Q_CH0) : (vc1 ? Q_CD1 : Q_CD0);
      default:    return Q_NP;
    endcase
  endfunction

endpackage

// File: rtl/tlpd_tc_map.sv
module tlpd_tc_map
  import tlpd_pkg::*;
#(
  parameter logic [NUM_TC-1:0] MAP_INIT = 8'hF0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [TC_W-1:0] wr_tc,
  input  logic            wr_vc,
  input  logic [TC_W-1:0] rd_tc,
  output logic            rd_vc
);

  logic [NUM_TC-1:0] map_q;

  for (genvar t = 0; t < NUM_TC; t++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        map_q[t] <= MAP_INIT[t];
      else if (wr_en && wr_tc == TC_W'(t))
        map_q[t] <= wr_vc;
    end
  end

  // class 0 is pinned to channel 0 on the read side
  always_comb rd_vc = (rd_tc == '0) ? 1'b0 : map_q[rd_tc];

endmodule

// File: rtl/tlpd_classify.sv
module tlpd_classify
  import tlpd_pkg::*;
(
  input  logic [2:0]  fmt,
  input  logic [4:0]  typ,
  input  logic        map_vc,
  input  logic        vc1_en,
  output tlp_class_e  cls,
  output logic        hdr4,
  output logic        use_vc1,
  output logic        bad_cpl
);

  always_comb begin
    cls     = decode_class(fmt, typ);
    hdr4    = fmt[0];
    bad_cpl = (cls == CLS_COMPL) && fmt[0];
    use_vc1 = vc1_en && map_vc && (cls != CLS_NONPOSTED);
  end

endmodule

// File: rtl/tlpd_steer.sv
module tlpd_steer
  import tlpd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  tlp_class_e        new_cls,
  input  logic              new_hdr4,
  input  logic              new_vc1,
  input  logic              new_bad,
  output logic [NUM_Q-1:0]  out_valid,
  input  logic [NUM_Q-1:0]  out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eop,
  output logic              err_pulse
);

  localparam int HDR_MAX = 4;
  localparam int CNT_W   = $clog2(HDR_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(HDR_MAX);
  localparam logic [CNT_W-1:0] HLEN3   = CNT_W'(3);
  localparam logic [CNT_W-1:0] HLEN4   = CNT_W'(4);

  // packet context captured on the first word
  tlp_class_e       ctx_cls;
  logic             ctx_hdr4, ctx_vc1, ctx_drop;
  logic [CNT_W-1:0] beat_cnt;

  // registered output stage
  logic              oq_valid;
  logic [QW-1:0]     oq_dest;
  logic [DATA_W-1:0] oq_data;
  logic              oq_eop;
  logic              err_q;

  tlp_class_e       cur_cls;
  logic             cur_hdr4, cur_vc1, cur_drop, cur_is_hdr;
  logic [CNT_W-1:0] cur_idx, nxt_cnt;
  logic [QW-1:0]    cur_dest;
  logic             accept;

  always_comb begin
    cur_cls    = in_sop ? new_cls  : ctx_cls;
    cur_hdr4   = in_sop ? new_hdr4 : ctx_hdr4;
    cur_vc1    = in_sop ? new_vc1  : ctx_vc1;
    cur_drop   = in_sop ? new_bad  : ctx_drop;
    cur_idx    = in_sop ? '0 : beat_cnt;
    cur_is_hdr = cur_idx < (cur_hdr4 ? HLEN4 : HLEN3);
    cur_dest   = pick_queue(cur_cls, cur_vc1, cur_is_hdr);
    nxt_cnt    = (cur_idx >= CNT_SAT) ? CNT_SAT : cur_idx + CNT_W'(1);
    in_ready   = !oq_valid || out_ready[oq_dest];
    accept     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_cls  <= CLS_POSTED;
      ctx_hdr4 <= 1'b0;
      ctx_vc1  <= 1'b0;
      ctx_drop <= 1'b0;
      beat_cnt <= '0;
      oq_valid <= 1'b0;
      oq_dest  <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= accept && in_sop && new_bad;
      if (accept) begin
        ctx_cls  <= cur_cls;
        ctx_hdr4 <= cur_hdr4;
        ctx_vc1  <= cur_vc1;
        ctx_drop <= cur_drop;
        beat_cnt <= nxt_cnt;
        oq_valid <= !cur_drop;
        oq_dest  <= cur_dest;
      end else if (oq_valid && out_ready[oq_dest]) begin
        oq_valid <= 1'b0;
      end
    end
  end

  // data path without reset so it maps onto plain register banks
  always_ff @(posedge clk) begin
    if (accept) begin
      oq_data <= in_data;
      oq_eop  <= in_eop;
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_vld
    always_comb out_valid[q] = oq_valid && (oq_dest == QW'(q));
  end

  always_comb begin
    out_data  = oq_data;
    out_eop   = oq_eop;
    err_pulse = err_q;
  end

endmodule

// File: rtl/tlp_tc_dispatch.sv
module tlp_tc_dispatch
  import tlpd_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [NUM_TC-1:0] MAP_INIT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [TC_W-1:0]   tbl_tc,
  input  logic              tbl_vc,
  input  logic              vc1_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic [NUM_Q-1:0]  out_valid,
  input  logic [NUM_Q-1:0]  out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eop,
  output logic              err_cpl4
);

  localparam int FMT_LO = 29;
  localparam int TYP_LO = 24;
  localparam int TC_LO  = 20;

  logic [2:0]      hdr_fmt;
  logic [4:0]      hdr_typ;
  logic [TC_W-1:0] hdr_tc;
  logic            map_vc;
  tlp_class_e      dec_cls;
  logic            dec_hdr4, dec_vc1, dec_bad;

  always_comb begin
    hdr_fmt = in_data[FMT_LO +: 3];
    hdr_typ = in_data[TYP_LO +: 5];
    hdr_tc  = in_data[TC_LO +: TC_W];
  end

  tlpd_tc_map #(.MAP_INIT(MAP_INIT)) u_map (
    .clk   (clk),
    .rst   (rst),
    .wr_en (tbl_we),
    .wr_tc (tbl_tc),
    .wr_vc (tbl_vc),
    .rd_tc (hdr_tc),
    .rd_vc (map_vc)
  );

  tlpd_classify u_cls (
    .fmt     (hdr_fmt),
    .typ     (hdr_typ),
    .map_vc  (map_vc),
    .vc1_en  (vc1_en),
    .cls     (dec_cls),
    .hdr4    (dec_hdr4),
    .use_vc1 (dec_vc1),
    .bad_cpl (dec_bad)
  );

  tlpd_steer #(.DATA_W(DATA_W)) u_steer (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .new_cls   (dec_cls),
    .new_hdr4  (dec_hdr4),
    .new_vc1   (dec_vc1),
    .new_bad   (dec_bad),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eop   (out_eop),
    .err_pulse (err_cpl4)
  );

endmodule

// File: rtl/tlpd_checker.sv
module tlpd_checker #(
  parameter int DATA_W = 32,
  parameter int NQ     = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic [NQ-1:0]     out_valid,
  input logic [NQ-1:0]     out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_eop,
  input logic              err_cpl4
);

  // R10: never more than one queue offered a word
  p_onehot_out_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));

  // R9: a blocked queue stalls the input
  p_stall_in_r9: assert property (@(posedge clk) disable iff (rst)
    (|(out_valid & ~out_ready)) |-> !in_ready);

  // R9: a blocked word is held unchanged
  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
    (|(out_valid & ~out_ready)) |=> ($stable(out_valid) && $stable(out_data) && $stable(out_eop)));

  // R8: the cycle that reports a malformed completion forwards nothing
  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    err_cpl4 |-> (out_valid == '0));

  // R8: the error is a single-cycle pulse
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    err_cpl4 |=> !err_cpl4);

endmodule

bind tlp_tc_dispatch tlpd_checker #(.DATA_W(DATA_W), .NQ(tlpd_pkg::NUM_Q)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_eop   (out_eop),
  .err_cpl4  (err_cpl4)
);

// File: tb/tlp_tc_dispatch_test.sv
module tlp_tc_dispatch_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_tc = '0;
  logic        tbl_vc = 1'b0;
  logic        vc1_en = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic [8:0]  out_ready = '1;
  logic        in_ready;
  logic [8:0]  out_valid;
  logic [31:0] out_data;
  logic        out_eop;
  logic        err_cpl4;

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 0;
  int err_seen = 0;
  int err_exp = 0;
  int seq = 0;
  logic [7:0]  bm = 8'hF0;
  logic [32:0] expq [9][$];

  always #2 clk = ~clk;

  tlp_tc_dispatch uut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_tc(tbl_tc), .tbl_vc(tbl_vc),
    .vc1_en(vc1_en), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_eop(out_eop), .err_cpl4(err_cpl4)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference queue choice, written from the requirement text
  function automatic int ref_queue(input logic [2:0] fmt, input logic [4:0] typ,
                                   input bit vc1, input bit hdr);
    int cls;
    if (typ[4:3] == 2'b10) cls = 0;
    else if (typ[4:1] == 4'b0101) cls = 2;
    else if (typ == 5'b0 && fmt[1]) cls = 0;
    else cls = 1;
    if (cls == 1) return 2;
    if (cls == 0) return hdr ? (vc1 ? 5 : 0) : (vc1 ? 6 : 1);
    return hdr ? (vc1 ? 7 : 3) : (vc1 ? 8 : 4);
  endfunction

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) out_ready = '1;
    else out_ready = 9'($urandom);
  end

  // output monitor, every clock
  always @(negedge clk) begin
    logic exp_rdy;
    logic [32:0] e;
    if (!rst) begin
      exp_rdy = !(|(out_valid & ~out_ready));
      chk(in_ready == exp_rdy, "R9", "in_ready", 64'(in_ready), 64'(exp_rdy));
      chk($countones(out_valid) <= 1, "R10", "out_valid onehot", 64'(out_valid), 64'(0));
      if (err_cpl4) err_seen++;
      for (int q = 0; q < 9; q++) begin
        if (out_valid[q] && out_ready[q]) begin
          if (expq[q].size() == 0) begin
            chk(1'b0, "R1", $sformatf("unexpected word on queue %0d", q),
                64'(out_data), 64'(0));
          end else begin
            e = expq[q].pop_front();
            chk({out_eop, out_data} == e, "R5",
                $sformatf("word/order on queue %0d", q), 64'({out_eop, out_data}), 64'(e));
          end
        end
      end
    end
  end

  task automatic send(input logic [2:0] fmt, input logic [4:0] typ, input logic [2:0] tc,
                      input int ndata, input bit wr, input logic [2:0] wtc,
                      input bit wvc, input int flip_at);
    int hl;
    int nb;
    bit bad;
    bit vc1;
    bit acc;
    logic [31:0] d;
    hl  = fmt[0] ? 4 : 3;
    nb  = hl + (fmt[1] ? ndata : 0);
    bad = (typ[4:1] == 4'b0101) && fmt[0];
    vc1 = 1'b0;
    seq++;
    for (int i = 0; i < nb; i++) begin
      d = (i == 0) ? {fmt, typ, 1'b0, tc, 4'h0, 16'(seq)} : {16'(seq), 16'(i)};
      in_valid = 1'b1;
      in_data  = d;
      in_sop   = (i == 0);
      in_eop   = (i == nb - 1);
      if (i == 0 && wr) begin
        tbl_we = 1'b1; tbl_tc = wtc; tbl_vc = wvc;
      end
      if (i == flip_at) vc1_en = !vc1_en;
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        if (in_ready) begin
          acc = 1'b1;
          if (i == 0) vc1 = vc1_en && (tc != 3'd0) && bm[tc];
          if (!bad) expq[ref_queue(fmt, typ, vc1, i < hl)].push_back({in_eop, d});
          if (i == 0 && bad) err_exp++;
        end
        @(posedge clk);
        #1;
        if (tbl_we) begin
          bm[tbl_tc] = tbl_vc;
          tbl_we = 1'b0;
        end
        if (acc && i == 0 && bad)
          chk(err_cpl4 == 1'b1, "R8", "error pulse after first word", 64'(err_cpl4), 64'(1));
      end
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic drained(input string tag);
    int tot;
    repeat (8) @(posedge clk);
    #1;
    tot = 0;
    for (int q = 0; q < 9; q++) tot += expq[q].size();
    chk(tot == 0, tag, "pending expected words", 64'(tot), 64'(0));
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(out_valid == '0, "R10", "out_valid after reset", 64'(out_valid), 64'(0));
    chk(err_cpl4 == 1'b0, "R10", "err after reset", 64'(err_cpl4), 64'(0));
    chk(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'(1));
    @(posedge clk);
    #1;

    // R4 R5: posted write, 3-word header, class 5 -> ch1 by preload (R3)
    send(3'b010, 5'b00000, 3'd5, 2, 0, 0, 0, -1);
    drained("R3");
    // R5: 4-word header memory write, class 2 -> ch0
    send(3'b011, 5'b00000, 3'd2, 3, 0, 0, 0, -1);
    drained("R5");
    // R4: message with data, class 6 -> ch1
    send(3'b011, 5'b10010, 3'd6, 1, 0, 0, 0, -1);
    drained("R4");
    // R6: memory read and config write, class mapping to ch1 still go to queue 2
    send(3'b000, 5'b00000, 3'd7, 0, 0, 0, 0, -1);
    send(3'b010, 5'b00100, 3'd4, 1, 0, 0, 0, -1);
    drained("R6");
    // R1: completion and completion with data on ch1 and ch0
    send(3'b000, 5'b01010, 3'd5, 0, 0, 0, 0, -1);
    send(3'b010, 5'b01010, 3'd3, 2, 0, 0, 0, -1);
    send(3'b010, 5'b01010, 3'd4, 1, 0, 0, 0, -1);
    drained("R1");
    // R8: malformed completion dropped, then a good packet still routes
    send(3'b011, 5'b01010, 3'd5, 2, 0, 0, 0, -1);
    send(3'b010, 5'b00000, 3'd1, 1, 0, 0, 0, -1);
    drained("R8");
    // R7: channel 1 disabled, then a mid-packet toggle
    vc1_en = 1'b0;
    send(3'b010, 5'b00000, 3'd6, 2, 0, 0, 0, -1);
    send(3'b010, 5'b01010, 3'd7, 3, 0, 0, 0, 2);
    send(3'b011, 5'b00000, 3'd5, 2, 0, 0, 0, 3);
    drained("R7");
    // R3: write class 3 -> ch1 on the same cycle as a class-3 first word
    vc1_en = 1'b1;
    send(3'b010, 5'b00000, 3'd3, 1, 1, 3'd3, 1'b1, -1);
    send(3'b010, 5'b00000, 3'd3, 1, 0, 0, 0, -1);
    drained("R3");
    // R2: class 0 stays on ch0 after writing its entry to 1
    send(3'b000, 5'b10000, 3'd1, 0, 1, 3'd0, 1'b1, -1);
    send(3'b010, 5'b00000, 3'd0, 2, 0, 0, 0, -1);
    send(3'b010, 5'b01010, 3'd0, 1, 0, 0, 0, -1);
    drained("R2");

    // R9: random traffic under per-queue backpressure
    rdy_mode = 1;
    for (int k = 0; k < 60; k++) begin
      int kind;
      logic [2:0] f;
      logic [4:0] t;
      kind = int'($urandom % 9);
      case (kind)
        0: begin f = 3'b010; t = 5'b00000; end
        1: begin f = 3'b011; t = 5'b00000; end
        2: begin f = 3'b000; t = 5'b00000; end
        3: begin f = 3'b010; t = 5'b00100; end
        4: begin f = 3'b001; t = 5'b10000; end
        5: begin f = 3'b000; t = 5'b01010; end
        6: begin f = 3'b010; t = 5'b01010; end
        7: begin f = 3'b011; t = 5'b01010; end
        default: begin f = 3'b000; t = 5'b00010; end
      endcase
      if (k % 7 == 3) vc1_en = !vc1_en;
      send(f, t, 3'($urandom), 1 + int'($urandom % 3),
           (k % 5 == 2), 3'($urandom), 1'($urandom), -1);
    end
    rdy_mode = 0;
    drained("R9");
    chk(err_seen == err_exp, "R8", "error pulse count", 64'(err_seen), 64'(err_exp));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule